// File: doc/BRIEF.md
# Legacy I/O Interrupt Aggregator

This block collects up to eight hardware interrupt sources into one level-sensitive line toward a chipset interrupt input. Sources set pending bits with a set strobe vector and remove them with a clear strobe vector. The pending bits are held in an 8-bit register. An enable vector decides which pending bits may drive the output. Software reaches the block over a simple byte-addressed register bus. Through that bus it writes a mask, acknowledges a single source by number, and reads the pending bits back.

A secondary controller exists only as storage: its mask can be written and read, but it never raises the line. The window also has addresses left over from timer, DMA, keyboard and speaker-port logic. Writes to those addresses complete with no error and change no state. Any other access, or any access with an unsupported size, is reported on the error signal in the same cycle.

Top module: `lio_irq_top`

## Requirements
- R1: A 1-byte write to address 0x21 stores the complement of the data as the enable vector, so a written 1 masks that source. A 1-byte read of 0x21 returns the value last written (0xFF after reset).
- R2: `irqOut` is high exactly when some pending bit has its enable bit set. It follows the registered state one clock after the edge that changes that state.
- R3: A mask write re-evaluates `irqOut` on the following cycle. It raises the line when enabled pending bits now exist and drops it when none remain.
- R4: A 1-byte write to 0x20 clears the pending bit whose index is `busWdata[3:0]`. Index values 8 to 15 leave the pending register unchanged.
- R5: `srcSet` ORs its vector into the pending register and `srcClr` removes its vector. Within one cycle an acknowledge write applies first, then the clear, and the set last.
- R6: A 1-byte write to 0xA1 stores its data without inversion, a 1-byte read of 0xA1 returns it, and it never changes `irqOut`. A 1-byte read of 0xA0 returns zero.
- R7: A read of 0x20 returns the pending register. Size codes are 0 = 1 byte and 3 = 8 bytes. An 8-byte read is legal only at 0x20 and returns the pending register zero-extended to 64 bits.
- R8: `busErr` is high in the same cycle for any access that is not listed: any write with a size code other than 0, any read of an unlisted address or size, or a read and write at once. Such an access changes no state and reads as zero.
- R9: 1-byte writes to 0x08, 0x0A, 0x0D, 0x0F, 0xD0, 0xD4, 0xDA, 0xDE, 0x60, 0x61 and 0xA0 complete without error and change no state.
- R10: After reset the pending register and the enable vector are zero and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset within the window |
| busSize | input | 2 | Access size code (0 = 1 byte, 3 = 8 bytes) |
| busRd | input | 1 | Read request this cycle |
| busWr | input | 1 | Write request this cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 64 | Read data, valid in the cycle of the read |
| busErr | output | 1 | Access rejected |
| srcSet | input | 8 | Pending bits to set |
| srcClr | input | 8 | Pending bits to clear |
| irqOut | output | 1 | Level interrupt toward the chipset |

## Verification
The bench tries the pending register with single-bit sets, several bits set at once, and overlapping set and clear vectors. These patterns separate the OR and AND-NOT paths and check their order of application. Masks are written both before and after bits become pending, which tests whether a mask write re-evaluates the line on its own. Acknowledge indices are swept across 0 to 15, so the high-half indices show whether any spurious clear occurs. Every address in the ignored set, plus sizes and addresses outside the legal ones, is accessed with pending bits and masks already set. Any state change or missing error then shows up in later reads and on the line.

// File: rtl/lio_irq_pkg.sv
`timescale 1ns/1ps
package lio_irq_pkg;
  localparam int NSRC = 8;
  localparam int AW   = 8;
  localparam int RDW  = 64;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_QUAD = 2'd3;

  localparam logic [AW-1:0] A_PRI_STAT = 8'h20;
  localparam logic [AW-1:0] A_PRI_ACK  = 8'h20;
  localparam logic [AW-1:0] A_PRI_MASK = 8'h21;
  localparam logic [AW-1:0] A_SEC_STAT = 8'hA0;
  localparam logic [AW-1:0] A_SEC_MASK = 8'hA1;

  localparam int N_IGN = 11;
  localparam logic [N_IGN*AW-1:0] IGN_ADDRS = {
    8'h08, 8'h0A, 8'h0D, 8'h0F, 8'hD0, 8'hD4,
    8'hDA, 8'hDE, 8'h60, 8'h61, 8'hA0
  };

  typedef struct packed {
    logic wrPriMask;
    logic wrSecMask;
    logic wrPriAck;
    logic rdPriMask;
    logic rdSecMask;
    logic rdPriStat;
    logic rdSecStat;
  } lioStrb_t;
endpackage

// File: rtl/lio_irq_ctrl.sv
`timescale 1ns/1ps
module lio_irq_ctrl
  import lio_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic [1:0]    busSize,
  input  logic          busRd,
  input  logic          busWr,
  output lioStrb_t      strb,
  output logic          busErr
);
  logic legal;
  logic ignHit;

  always_comb begin
    ignHit = 1'b0;
    for (int i = 0; i < N_IGN; i++) begin
      if (busAddr == IGN_ADDRS[i*AW +: AW]) ignHit = 1'b1;
    end
  end

  always_comb begin
    strb  = '0;
    legal = 1'b0;
    if (busWr && !busRd && busSize == SZ_BYTE) begin
      if (busAddr == A_PRI_MASK) begin
        strb.wrPriMask = 1'b1;
        legal = 1'b1;
      end else if (busAddr == A_SEC_MASK) begin
        strb.wrSecMask = 1'b1;
        legal = 1'b1;
      end else if (busAddr == A_PRI_ACK) begin
        strb.wrPriAck = 1'b1;
        legal = 1'b1;
      end else if (ignHit) begin
        legal = 1'b1;
      end
    end else if (busRd && !busWr) begin
      if (busSize == SZ_BYTE) begin
        if (busAddr == A_PRI_MASK) begin
          strb.rdPriMask = 1'b1;
          legal = 1'b1;
        end else if (busAddr == A_SEC_MASK) begin
          strb.rdSecMask = 1'b1;
          legal = 1'b1;
        end else if (busAddr == A_PRI_STAT) begin
          strb.rdPriStat = 1'b1;
          legal = 1'b1;
        end else if (busAddr == A_SEC_STAT) begin
          strb.rdSecStat = 1'b1;
          legal = 1'b1;
        end
      end else if (busSize == SZ_QUAD && busAddr == A_PRI_STAT) begin
        strb.rdPriStat = 1'b1;
        legal = 1'b1;
      end
    end
  end

  assign busErr = (busRd || busWr) && !legal;

  // R8: a wide write never produces a state-changing strobe
  a_r8_wide_write_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSize != SZ_BYTE) |-> (busErr && !strb.wrPriMask && !strb.wrSecMask && !strb.wrPriAck));
endmodule

// File: rtl/lio_irq_dp.sv
`timescale 1ns/1ps
module lio_irq_dp
  import lio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  lioStrb_t        strb,
  input  logic [NSRC-1:0] busWdata,
  input  logic [NSRC-1:0] srcSet,
  input  logic [NSRC-1:0] srcClr,
  output logic [RDW-1:0]  busRdata,
  output logic            irqOut
);
  localparam int IDXW = $clog2(NSRC);

  logic [NSRC-1:0] pendReg;
  logic [NSRC-1:0] enReg;
  logic [NSRC-1:0] secReg;
  logic [NSRC-1:0] ackClr;
  logic [NSRC-1:0] pendNext;
  logic [3:0]      ackIdx;

  assign ackIdx = busWdata[3:0];

  always_comb begin
    ackClr = '0;
    if (strb.wrPriAck && ackIdx < 4'(NSRC)) ackClr[ackIdx[IDXW-1:0]] = 1'b1;
  end

  assign pendNext = ((pendReg & ~ackClr) & ~srcClr) | srcSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
      enReg   <= '0;
      secReg  <= '0;
    end else begin
      pendReg <= pendNext;
      if (strb.wrPriMask) enReg  <= ~busWdata;
      if (strb.wrSecMask) secReg <= busWdata;
    end
  end

  assign irqOut = |(pendReg & enReg);

  always_comb begin
    busRdata = '0;
    if (strb.rdPriMask)      busRdata[NSRC-1:0] = ~enReg;
    else if (strb.rdSecMask) busRdata[NSRC-1:0] = secReg;
    else if (strb.rdPriStat) busRdata[NSRC-1:0] = pendReg;
  end

  // R1: enable vector changes only through a primary mask write
  a_r1_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPriMask |=> $stable(enReg));

  // R3: a mask write alone sets the line from the new enable vector
  a_r3_mask_reeval: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPriMask && srcSet == '0 && srcClr == '0 && !strb.wrPriAck)
      |=> irqOut == |($past(pendReg) & ~$past(busWdata)));

  // R4: acknowledged index is gone next cycle unless re-set
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPriAck && !busWdata[3] && srcSet == '0) |=> pendReg[$past(busWdata[2:0])] == 1'b0);

  // R5: set wins and reaches an enabled line
  a_r5_set_raises: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcSet & enReg) && !strb.wrPriMask) |=> irqOut);

  // R6: secondary mask write alone leaves the line alone
  a_r6_sec_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSecMask && srcSet == '0 && srcClr == '0) |=> $stable(irqOut));
endmodule

// File: rtl/lio_irq_top.sv
`timescale 1ns/1ps
module lio_irq_top
  import lio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic [1:0]  busSize,
  input  logic        busRd,
  input  logic        busWr,
  input  logic [7:0]  busWdata,
  output logic [63:0] busRdata,
  output logic        busErr,
  input  logic [7:0]  srcSet,
  input  logic [7:0]  srcClr,
  output logic        irqOut
);
  lioStrb_t strb;

  lio_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busSize (busSize),
    .busRd   (busRd),
    .busWr   (busWr),
    .strb    (strb),
    .busErr  (busErr)
  );

  lio_irq_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .srcSet   (srcSet),
    .srcClr   (srcClr),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/test_lio_irq_top.sv
`timescale 1ns/1ps
module test_lio_irq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [63:0] busRdata;
  logic        busErr;
  logic [7:0]  srcSet = '0;
  logic [7:0]  srcClr = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mPend = 0;
  int mEn = 0;
  int mSec = 0;
  int ignList[$] = '{8'h08, 8'h0A, 8'h0D, 8'h0F, 8'hD0, 8'hD4, 8'hDA, 8'hDE, 8'h60, 8'h61, 8'hA0};

  always #2 clk = ~clk;

  lio_irq_top i_lio_irq_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busSize(busSize),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .srcSet(srcSet), .srcClr(srcClr), .irqOut(irqOut)
  );

  function automatic bit modelLegal();
    if (busRd && busWr) return 0;
    if (busWr) begin
      if (busSize != 0) return 0;
      if (busAddr == 8'h20 || busAddr == 8'h21 || busAddr == 8'hA1) return 1;
      foreach (ignList[k]) if (busAddr == ignList[k]) return 1;
      return 0;
    end
    if (busRd) begin
      if (busSize == 3) return busAddr == 8'h20;
      if (busSize != 0) return 0;
      return busAddr == 8'h20 || busAddr == 8'h21 || busAddr == 8'hA0 || busAddr == 8'hA1;
    end
    return 1;
  endfunction

  function automatic longint modelRead();
    if (!busRd || !modelLegal()) return 0;
    case (busAddr)
      8'h20: return longint'(mPend);
      8'h21: return longint'((~mEn) & 255);
      8'hA1: return longint'(mSec);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one clock, update the model, then compare the line
  task automatic step(string tag);
    @(posedge clk);
    if (!rstN) begin
      mPend = 0; mEn = 0; mSec = 0;
    end else begin
      if (busWr && modelLegal()) begin
        if (busAddr == 8'h20 && (busWdata & 15) < 8) mPend &= ~(1 << (busWdata & 15));
        if (busAddr == 8'h21) mEn = (~busWdata) & 255;
        if (busAddr == 8'hA1) mSec = busWdata;
      end
      mPend &= ~int'(srcClr);
      mPend |= int'(srcSet);
    end
    @(negedge clk);
    busRd = 0; busWr = 0; busSize = 0; srcSet = 0; srcClr = 0;
    #1;
    check({tag, " R2 irq"}, longint'(irqOut), longint'((mPend & mEn) != 0));
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag, logic [1:0] sz = 0);
    busAddr = a; busWdata = d; busSize = sz; busWr = 1;
    #1;
    check({tag, " err"}, longint'(busErr), longint'(!modelLegal()));
    step(tag);
  endtask

  task automatic rd(logic [7:0] a, string tag, logic [1:0] sz = 0);
    busAddr = a; busSize = sz; busRd = 1;
    #1;
    check({tag, " err"}, longint'(busErr), longint'(!modelLegal()));
    check({tag, " data"}, longint'(busRdata), modelRead());
    step(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R10 reset");
    step("R10 reset");
    rstN = 1;
    #1;
    check("R10 irq low after reset", longint'(irqOut), 0);
    rd(8'h20, "R10 pending zero");
    rd(8'h21, "R1 mask reset 0xFF");

    // R5: single and multi-bit sets with all masked
    srcSet = 8'h01; step("R5 set bit0 masked");
    srcSet = 8'h90; step("R5 set multi");
    rd(8'h20, "R7 status 91");
    // R3: unmask pending bits raises the line
    wr(8'h21, 8'hFE, "R3 unmask bit0");
    rd(8'h21, "R1 mask readback");
    wr(8'h21, 8'hFF, "R3 mask all drops");
    wr(8'h21, 8'h6F, "R3 unmask 4 and 7");
    // R4: acknowledge sweep 0..15
    for (int i = 15; i >= 0; i--) begin
      wr(8'h20, 8'(i), "R4 ack index");
      rd(8'h20, "R4 pending after ack");
    end
    // R5: overlap, set after clear, ack first
    srcSet = 8'hF0; step("R5 setup");
    srcSet = 8'h30; srcClr = 8'h3C; step("R5 set wins over clear");
    rd(8'h20, "R5 pending check");
    busAddr = 8'h20; busWdata = 8'h05; busWr = 1; srcSet = 8'h20; srcClr = 8'h40;
    step("R5 ack clear set same cycle");
    rd(8'h20, "R5 ordered result");
    srcClr = 8'hFF; step("R5 clear all");
    srcSet = 8'h80; step("R2 raise bit7");
    // R6: secondary mask
    wr(8'hA1, 8'h5A, "R6 sec mask write");
    rd(8'hA1, "R6 sec mask read");
    rd(8'hA0, "R6 sec status zero");
    // R7: wide read
    rd(8'h20, "R7 wide status", 2'd3);
    rd(8'h21, "R8 wide read bad addr", 2'd3);
    rd(8'h20, "R8 half read", 2'd1);
    // R8: bad writes change nothing
    wr(8'h21, 8'h00, "R8 wide write", 2'd3);
    wr(8'h21, 8'h00, "R8 two-byte write", 2'd1);
    wr(8'h33, 8'h00, "R8 unlisted addr");
    rd(8'h08, "R8 unlisted read");
    busAddr = 8'h21; busWdata = 8'h00; busRd = 1; busWr = 1;
    #1; check("R8 read and write err", longint'(busErr), 1);
    step("R8 rd+wr");
    rd(8'h21, "R8 mask unchanged");
    // R9: ignored addresses
    foreach (ignList[k]) wr(8'(ignList[k]), 8'h00, "R9 ignored write");
    rd(8'h20, "R9 pending kept");
    rd(8'h21, "R9 mask kept");
    rd(8'hA1, "R9 sec kept");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule